// File: doc/BRIEF.md
# Sample FIFO with Threshold Interrupt

This block buffers converted samples between a scan sequencer and a host bus. The sequencer pushes 16-bit words, and the host removes them by reading. The block keeps an occupancy count, and it raises full and half-full flags from that count. It also drives a level interrupt. The interrupt is asserted while occupancy is at or above a threshold the host has programmed, and it drops by itself once the host has drained the FIFO below that threshold.

The block also reports which channel of the scan group sits at the head of the queue. This head index steps once per pop and returns to zero after the configured last group index. The host side can read a word in two ways. A full-word read pops an entry, and so does a read of the high data byte. A read of the low byte alone leaves the queue untouched, so a byte-wide host can read the low byte first and then the high byte.

An activity output stretches every pop into a pulse long enough to drive a visible indicator. A synchronous clear empties the queue and resets the head index. The programmed threshold survives a clear.

Top module: `sample_fifo_irq`

## Requirements
- R1: After reset the following outputs are 0: count, full, half, irq, head_chan and led. The threshold is DEPTH/2.
- R2: Popped words leave in push order. rd_data shows the popped word from the clock edge that performs the pop.
- R3: A push while count equals DEPTH, with no pop in the same cycle, is discarded. count never exceeds DEPTH.
- R4: A pop while count is 0 is ignored. count, rd_data and head_chan keep their values.
- R5: When a push and a valid pop share a cycle, count is unchanged. If the FIFO is empty, the pop is ignored and count rises by 1.
- R6: full is 1 exactly when count equals DEPTH. half is 1 exactly when count is at least DEPTH/2.
- R7: irq is 1 exactly when irq_en is 1 and count is at least the threshold. A thresh_we pulse loads thresh_data as the new threshold.
- R8: head_chan is 0 after reset or clear. Each valid pop raises it by 1, except that a pop made while head_chan is at or above group_last returns it to 0.
- R9: A pulse on pop_word or on pop_hi performs one pop, and so does a pulse on both at once. A pulse on rd_lo alone never pops.
- R10: clr sets count and head_chan to 0 on the next edge. It keeps the threshold and rd_data.
- R11: led is 1 for LED_HOLD cycles after a valid pop, starting at the edge of the pop, and is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of the queue and the head index |
| push | input | 1 | Sequencer write strobe |
| push_data | input | DATA_W (16) | Sample word to store |
| pop_word | input | 1 | Host full-word read strobe (pops) |
| pop_hi | input | 1 | Host high-byte read strobe (pops) |
| rd_lo | input | 1 | Host low-byte read strobe (never pops) |
| thresh_we | input | 1 | Load strobe for the interrupt threshold |
| thresh_data | input | CNT_W (10) | New interrupt threshold |
| irq_en | input | 1 | Interrupt enable |
| group_last | input | GROUP_W (5) | Last head index before wrap |
| rd_data | output | DATA_W (16) | Most recently popped word |
| count | output | CNT_W (10) | Occupancy |
| full | output | 1 | Occupancy equals DEPTH |
| half | output | 1 | Occupancy at least DEPTH/2 |
| head_chan | output | GROUP_W (5) | Channel index at the queue head |
| irq | output | 1 | Level interrupt |
| led | output | 1 | Stretched pop activity |

## Verification
If a pointer is wrong, the next pop shows it on rd_data at once. If the occupancy counter is wrong, count, full, half and irq differ on the first edge after the faulty operation. The bench therefore compares all six observable outputs after every single operation. A wrong head index shows on head_chan after the pop that made it. A wrong stretch length shows on led within LED_HOLD cycles of the last pop.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  // occupancy comparison used for the half flag and the interrupt
  function automatic bit reaches(input int unsigned cnt, input int unsigned lim);
    return cnt >= lim;
  endfunction

  function automatic bit is_full(input int unsigned cnt, input int unsigned depth);
    return cnt == depth;
  endfunction

  // head index after one pop
  function automatic int unsigned next_head(input int unsigned h, input int unsigned last);
    return (h >= last) ? 0 : h + 1;
  endfunction
endpackage

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      rd_data <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (rd_en) begin
        rd_data <= mem[rd_ptr];
        rd_ptr  <= rd_ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fifo_occupancy.sv
module fifo_occupancy #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            count <= '0;
    else if (clr)          count <= '0;
    else if (inc && !dec)  count <= count + 1'b1;
    else if (dec && !inc)  count <= count - 1'b1;
  end
endmodule

// File: rtl/head_tracker.sv
module head_tracker #(
  parameter int GROUP_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               adv,
  input  logic [GROUP_W-1:0] last,
  output logic [GROUP_W-1:0] head
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   head <= '0;
    else if (clr) head <= '0;
    else if (adv) head <= GROUP_W'(sfifo_pkg::next_head(int'(head), int'(last)));
  end
endmodule

// File: rtl/activity_stretch.sv
module activity_stretch #(
  parameter int HOLD = 1_600_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic led
);
  localparam int TW = $clog2(HOLD + 1);

  logic [TW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain <= '0;
    else if (kick)            remain <= TW'(HOLD);
    else if (remain != '0)    remain <= remain - 1'b1;
  end

  assign led = (remain != '0);
endmodule

// File: rtl/sample_fifo_irq.sv
module sample_fifo_irq #(
  parameter int DEPTH    = 512,
  parameter int DATA_W   = 16,
  parameter int GROUP_W  = 5,
  parameter int LED_HOLD = 1_600_000,
  localparam int CNT_W   = $clog2(DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               push,
  input  logic [DATA_W-1:0]  push_data,
  input  logic               pop_word,
  input  logic               pop_hi,
  input  logic               rd_lo,
  input  logic               thresh_we,
  input  logic [CNT_W-1:0]   thresh_data,
  input  logic               irq_en,
  input  logic [GROUP_W-1:0] group_last,
  output logic [DATA_W-1:0]  rd_data,
  output logic [CNT_W-1:0]   count,
  output logic               full,
  output logic               half,
  output logic [GROUP_W-1:0] head_chan,
  output logic               irq,
  output logic               led
);
  // named internal events, observed by the bound checker
  logic             pop_ok;
  logic             push_ok;
  logic [CNT_W-1:0] thresh;
  logic             unused_rd_lo;

  assign unused_rd_lo = rd_lo; // low-byte read: data only, no pop (R9)

  assign pop_ok  = !clr && (pop_word || pop_hi) && (count != '0);
  assign push_ok = !clr && push && (!full || pop_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         thresh <= CNT_W'(DEPTH / 2);
    else if (thresh_we) thresh <= thresh_data;
  end

  fifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr_en(push_ok), .wr_data(push_data),
    .rd_en(pop_ok), .rd_data(rd_data)
  );

  fifo_occupancy #(.CNT_W(CNT_W)) u_occ (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .inc(push_ok), .dec(pop_ok), .count(count)
  );

  head_tracker #(.GROUP_W(GROUP_W)) u_head (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .adv(pop_ok), .last(group_last), .head(head_chan)
  );

  activity_stretch #(.HOLD(LED_HOLD)) u_led (
    .clk(clk), .rst_n(rst_n), .kick(pop_ok), .led(led)
  );

  assign full = sfifo_pkg::is_full(int'(count), DEPTH);
  assign half = sfifo_pkg::reaches(int'(count), DEPTH / 2);
  assign irq  = irq_en && sfifo_pkg::reaches(int'(count), int'(thresh));
endmodule

// File: rtl/sample_fifo_irq_chk.sv
module sample_fifo_irq_chk #(
  parameter int DEPTH   = 512,
  parameter int GROUP_W = 5,
  parameter int CNT_W   = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clr,
  input logic               push_ok,
  input logic               pop_ok,
  input logic               full,
  input logic [CNT_W-1:0]   count,
  input logic [CNT_W-1:0]   thresh,
  input logic               irq,
  input logic               irq_en,
  input logic               led,
  input logic [GROUP_W-1:0] head_chan,
  input logic [GROUP_W-1:0] group_last
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop_ok) |-> !push_ok);

  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !pop_ok);

  p_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok) |=> (count == CNT_W'($past(count) + 1'b1)));

  p_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> $stable(count));

  p_irq_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);

  p_irq_below_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (count < thresh) |-> !irq);

  p_head_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && head_chan >= group_last) |=> (head_chan == '0));

  p_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0 && head_chan == '0));

  p_led_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> led);
endmodule

bind sample_fifo_irq sample_fifo_irq_chk #(
  .DEPTH(DEPTH), .GROUP_W(GROUP_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .push_ok(push_ok), .pop_ok(pop_ok),
  .full(full), .count(count), .thresh(thresh), .irq(irq), .irq_en(irq_en),
  .led(led), .head_chan(head_chan), .group_last(group_last)
);

// File: tb/sim_sample_fifo_irq.sv
module sim_sample_fifo_irq;
  localparam int D  = 16;
  localparam int GW = 3;
  localparam int H  = 5;
  localparam int CW = $clog2(D) + 1;

  logic clk = 0, rst_n = 0, clr = 0, push = 0, pop_word = 0, pop_hi = 0, rd_lo = 0;
  logic thresh_we = 0, irq_en = 1;
  logic [15:0] push_data = '0;
  logic [CW-1:0] thresh_data = '0;
  logic [GW-1:0] group_last = 3'd2;
  logic [15:0] rd_data;
  logic [CW-1:0] count;
  logic full, half, irq, led;
  logic [GW-1:0] head_chan;

  always #5 clk = ~clk;

  sample_fifo_irq #(.DEPTH(D), .DATA_W(16), .GROUP_W(GW), .LED_HOLD(H)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push(push), .push_data(push_data),
    .pop_word(pop_word), .pop_hi(pop_hi), .rd_lo(rd_lo), .thresh_we(thresh_we),
    .thresh_data(thresh_data), .irq_en(irq_en), .group_last(group_last),
    .rd_data(rd_data), .count(count), .full(full), .half(half),
    .head_chan(head_chan), .irq(irq), .led(led)
  );

  int checks = 0, errors = 0;
  logic [15:0] mq [0:1023];
  int wr_n = 0, rd_n = 0, hd = 0, th = D / 2;
  logic [15:0] last_rd = '0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    int c;
    c = wr_n - rd_n;
    chk({req, " count"}, int'(count), c);
    chk({req, " full R6"}, int'(full), int'(c == D));
    chk({req, " half R6"}, int'(half), int'(c >= D / 2));
    chk({req, " irq R7"}, int'(irq), int'(irq_en && c >= th));
    chk({req, " head R8"}, int'(head_chan), hd);
    chk({req, " rd_data R2"}, int'(rd_data), int'(last_rd));
  endtask

  task automatic step(input bit ps, input logic [15:0] d, input bit pw, input bit ph, input bit rl);
    int c;
    bit pok, sok;
    @(negedge clk);
    push = ps; push_data = d; pop_word = pw; pop_hi = ph; rd_lo = rl;
    @(posedge clk); #1;
    push = 0; pop_word = 0; pop_hi = 0; rd_lo = 0;
    c = wr_n - rd_n;
    pok = (pw || ph) && c > 0;
    sok = ps && (c < D || pok);
    if (pok) begin
      last_rd = mq[rd_n % 1024];
      rd_n++;
      hd = (hd >= int'(group_last)) ? 0 : hd + 1;
    end
    if (sok) begin
      mq[wr_n % 1024] = d;
      wr_n++;
    end
  endtask

  task automatic set_thresh(input int t);
    @(negedge clk);
    thresh_we = 1; thresh_data = CW'(t);
    @(posedge clk); #1;
    thresh_we = 0;
    th = t;
  endtask

  task automatic do_clr();
    @(negedge clk); clr = 1;
    @(posedge clk); #1; clr = 0;
    rd_n = wr_n; hd = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    // R1 reset state
    check_all("R1");
    chk("R1 led", int'(led), 0);

    // R6 R7: fill sweep with default threshold D/2
    for (int i = 0; i < D; i++) begin
      step(1, 16'hA000 + 16'(i * 37), 0, 0, 0);
      check_all("R6 fill");
    end
    // R3: push into full is discarded
    step(1, 16'hDEAD, 0, 0, 0);
    check_all("R3 overflow");
    // R5: push and pop on full keeps count
    step(1, 16'hBEEF, 1, 0, 0);
    check_all("R5 full push+pop");

    // R2 R8 R9 R11: drain with mixed read strobes
    for (int i = 0; i < D; i++) begin
      step(0, '0, (i % 3) != 1, (i % 3) != 0, 0);
      check_all("R2 drain");
      chk("R11 led on pop", int'(led), 1);
    end
    // R4: pop on empty
    step(0, '0, 1, 0, 0);
    check_all("R4 empty pop");
    step(0, '0, 0, 1, 0);
    check_all("R4 empty pop hi");

    // R11: stretch length after the last real pop
    do_clr();
    step(1, 16'h1234, 0, 0, 0);
    step(0, '0, 1, 0, 0);
    repeat (H - 1) @(posedge clk);
    #1 chk("R11 led held", int'(led), 1);
    @(posedge clk); #1 chk("R11 led released", int'(led), 0);

    // R9: low-byte read alone never pops
    step(1, 16'h00C3, 0, 0, 0);
    step(0, '0, 0, 0, 1);
    check_all("R9 rd_lo");
    chk("R9 led idle", int'(led), 0);

    // R5: push with pop when one entry present; then empty push+pop
    step(1, 16'h5A5A, 1, 0, 0);
    check_all("R5 steady");
    step(0, '0, 1, 0, 0);
    step(1, 16'h7777, 1, 0, 0);
    check_all("R5 empty push+pop");

    // R8: wrap at other group_last values
    for (int g = 0; g < 4; g++) begin
      do_clr();
      group_last = GW'(g);
      for (int i = 0; i < 7; i++) step(1, 16'(100 + i), 0, 0, 0);
      for (int i = 0; i < 7; i++) begin
        step(0, '0, 1, 0, 0);
        check_all("R8 wrap");
      end
    end

    // R7: threshold sweep at occupancy 5, enabled and disabled
    do_clr();
    for (int i = 0; i < 5; i++) step(1, 16'(i), 0, 0, 0);
    for (int t = 0; t <= D; t++) begin
      set_thresh(t);
      irq_en = 1; #1 check_all("R7 en");
      irq_en = 0; #1 check_all("R7 dis");
    end
    irq_en = 1;
    // R7: interrupt drops by itself when count falls below threshold
    set_thresh(5);
    check_all("R7 at thresh");
    step(0, '0, 1, 0, 0);
    check_all("R7 self clear");

    // R10: clear keeps threshold and rd_data
    set_thresh(0);
    step(1, 16'h0F0F, 0, 0, 0);
    step(0, '0, 1, 0, 0);
    do_clr();
    check_all("R10 clear");
    chk("R10 thresh kept", int'(irq), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule